// File: doc/BRIEF.md
# Dual-Rate Over-Current Trip Filter

This block decides when the breaker of a hot-swap supply has to open. An external comparator turns the drop across a sense resistor into one logic bit that is high while the drop exceeds the 50 mV threshold. The block synchronizes that bit and samples it on a prescaler tick. It counts consecutive over-current samples and, on the eighth, sets a latched trip flag that forces every gate-drive enable low in the same cycle.

The sample interval follows the power phase. While the power switches are still turning on (`sw_on` low), the bit is sampled every 500 ns, so a dead short is cut off after about 4 µs. Once `sw_on` is high, the interval becomes 2 µs, and the same eight-sample rule gives a 16 µs response that rides through brief current spikes. The block has no data stream, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. Intervals are set in nanoseconds and converted to cycles from the clock-frequency parameter. At the default 100 MHz the intervals are 50 and 200 cycles.

Top module: `oc_trip_filter`

## Requirements
- R1: After reset, `trip` is 0 and `gate_en` is all ones.
- R2: With `sw_on` low, the synchronized over-current bit is sampled once every FAST_NS (default 50 cycles).
- R3: Eight consecutive over-current samples set `trip`. With `oc_raw` held high from a cleared state, `trip` rises between 7*DIV and 8*DIV+3 cycles later, where DIV is the active sample interval in cycles. This includes the two-flop input synchronizer.
- R4: With `sw_on` high, the sample interval is SLOW_NS (default 200 cycles), and the same eight-sample count applies.
- R5: While `trip` is 1, `gate_en` is all zeros. While `trip` is 0, `gate_en` is all ones.
- R6: A sample that is not over-current resets the consecutive count to zero, so interrupted runs of fewer than eight samples never trip.
- R7: A change of `sw_on` restarts the prescaler and clears the count. After a change of phase, eight new samples at the new rate are needed.
- R8: `trip` stays set until `trip_clr` is pulsed or reset is applied, whatever `oc_raw` does. No counting happens while tripped. After a clear, a full new run of eight samples is needed before the next trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_raw | input | 1 | Asynchronous comparator output, 1 = over-current |
| sw_on | input | 1 | 1 = power switches fully on (steady-state phase) |
| trip_clr | input | 1 | One-cycle strobe that clears a latched trip |
| trip | output | 1 | Latched trip flag |
| gate_en | output | NUM_GATES | Gate-drive enables, forced to zero on trip |

## Verification
On every cycle, the assertions check that the consecutive count stays below eight and that it advances only on a tick that saw over-current. They also check that a trip rises only on a tick with the synchronized bit high, that a phase change never coincides with a new trip, and that a latched trip holds until it is cleared. The bench scenarios show what is visible only from outside: the trip latency in each phase, lying between seven and eight intervals, and runs of six or seven samples that do not trip. They also cover a run broken by one low sample, the fresh count needed after a phase change or a clear, and the gate mask following the flag.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;
  typedef enum logic {
    PH_RAMP = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  function automatic int ns_to_cycles(input int clk_mhz, input int ns);
    return (clk_mhz * ns) / 1000;
  endfunction
endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/oc_rate_tick.sv
module oc_rate_tick
  import oc_trip_pkg::*;
#(
  parameter int FAST_DIV = 50,
  parameter int SLOW_DIV = 200
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   restart,
  output logic   tick
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = (phase == PH_RUN) ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
  assign tick = !restart && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < SLOW_DIV);

  p_restart_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/oc_run_counter.sv
module oc_run_counter #(
  parameter int HITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic oc,
  input  logic restart,
  input  logic hold,
  output logic fire
);
  localparam int HW = $clog2(HITS + 1);

  logic [HW-1:0] hits;

  assign fire = tick && oc && !hold && !restart && (hits == HW'(HITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                hits <= '0;
    else if (restart || hold)  hits <= '0;
    else if (tick) begin
      if (!oc || fire)         hits <= '0;
      else                     hits <= hits + 1'b1;
    end
  end

  p_hits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hits) < HITS);

  p_step_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0 && hits != $past(hits)) |-> $past(tick && oc));
endmodule

// File: rtl/oc_trip_filter.sv
module oc_trip_filter
  import oc_trip_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int FAST_NS   = 500,
  parameter int SLOW_NS   = 2000,
  parameter int HITS      = 8,
  parameter int NUM_GATES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 oc_raw,
  input  logic                 sw_on,
  input  logic                 trip_clr,
  output logic                 trip,
  output logic [NUM_GATES-1:0] gate_en
);
  localparam int FAST_DIV = ns_to_cycles(CLK_MHZ, FAST_NS);
  localparam int SLOW_DIV = ns_to_cycles(CLK_MHZ, SLOW_NS);

  logic   oc_s;
  logic   tick;
  logic   fire;
  logic   restart;
  logic   trip_q;
  phase_e phase_q;

  oc_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(oc_raw), .q_sync(oc_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_RAMP;
    else        phase_q <= phase_e'(sw_on);
  end

  assign restart = (phase_e'(sw_on) != phase_q);

  oc_rate_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .phase(phase_q), .restart(restart), .tick(tick)
  );

  oc_run_counter #(.HITS(HITS)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .oc(oc_s),
    .restart(restart), .hold(trip_q), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        trip_q <= 1'b0;
    else if (fire)     trip_q <= 1'b1;
    else if (trip_clr) trip_q <= 1'b0;
  end

  assign trip    = trip_q;
  assign gate_en = trip_q ? '0 : '1;

  p_trip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !trip_clr) |=> trip_q);

  p_trip_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(tick && oc_s));

  p_no_trip_on_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !$rose(trip_q));
endmodule

// File: tb/test_oc_trip_filter.sv
module test_oc_trip_filter;
  localparam int FAST = 50;
  localparam int SLOW = 200;
  localparam int NG   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_raw = 1'b0;
  logic sw_on = 1'b0;
  logic trip_clr = 1'b0;
  logic trip;
  logic [NG-1:0] gate_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  oc_trip_filter #(.NUM_GATES(NG)) i_oc_trip_filter (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .sw_on(sw_on),
    .trip_clr(trip_clr), .trip(trip), .gate_en(gate_en)
  );

  // vector: [17] sw_on, [16] expected trip, [15:0] high-time in cycles
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd300},
    {1'b0, 1'b0, 16'd350},
    {1'b0, 1'b1, 16'd420},
    {1'b1, 1'b0, 16'd1400},
    {1'b1, 1'b1, 16'd1700},
    {1'b0, 1'b1, 16'd600}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle(input logic sw);
    oc_raw = 1'b0;
    sw_on  = sw;
    wait_n(3 * SLOW);
    trip_clr = 1'b1;
    wait_n(1);
    trip_clr = 1'b0;
    wait_n(2);
  endtask

  task automatic measure(input int maxc, output int n);
    n = 0;
    while (!trip && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n;

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(trip == 1'b0, "R1 trip", int'(trip), 0);
    check(gate_en == '1, "R1 gate_en", int'(gate_en), 15);

    // R2/R3 fast-phase latency
    idle(1'b0);
    oc_raw = 1'b1;
    measure(12 * FAST, n);
    check(n >= 7 * FAST && n <= 8 * FAST + 3, "R2 R3 fast latency", n, 8 * FAST);
    check(gate_en == '0, "R5 gate off on trip", int'(gate_en), 0);

    // R8 latched while input drops
    oc_raw = 1'b0;
    wait_n(4 * FAST);
    check(trip == 1'b1, "R8 trip held", int'(trip), 1);
    trip_clr = 1'b1; wait_n(1); trip_clr = 1'b0;
    check(trip == 1'b0, "R8 cleared", int'(trip), 0);
    check(gate_en == '1, "R5 gate on after clear", int'(gate_en), 15);

    // R4 slow-phase latency
    idle(1'b1);
    oc_raw = 1'b1;
    measure(12 * SLOW, n);
    check(n >= 7 * SLOW && n <= 8 * SLOW + 3, "R4 slow latency", n, 8 * SLOW);

    // R8 re-trip after clear while input stays high needs a full fresh run
    trip_clr = 1'b1; wait_n(1); trip_clr = 1'b0;
    measure(12 * SLOW, n);
    check(n >= 7 * SLOW - 1 && n <= 8 * SLOW + 3, "R8 fresh run after clear", n, 8 * SLOW);

    // R6 one low sample breaks the run
    idle(1'b0);
    oc_raw = 1'b1; wait_n(6 * FAST);
    oc_raw = 1'b0; wait_n(2 * FAST);
    oc_raw = 1'b1; wait_n(6 * FAST);
    oc_raw = 1'b0; wait_n(3);
    check(trip == 1'b0, "R6 broken run no trip", int'(trip), 0);

    // R7 phase change clears count
    idle(1'b0);
    oc_raw = 1'b1; wait_n(5 * FAST + 10);
    sw_on = 1'b1;
    wait_n(7 * SLOW - 10);
    check(trip == 1'b0, "R7 no trip before fresh slow run", int'(trip), 0);
    measure(3 * SLOW, n);
    check(trip == 1'b1, "R7 trip after fresh slow run", int'(trip), 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      idle(VEC[v][17]);
      oc_raw = 1'b1;
      wait_n(int'(VEC[v][15:0]));
      oc_raw = 1'b0;
      wait_n(3);
      check(trip == VEC[v][16], VEC[v][17] ? "R4 R3 vector" : "R2 R3 vector",
            int'(trip), int'(VEC[v][16]));
      check(gate_en == (trip ? 4'h0 : 4'hF), "R5 vector mask", int'(gate_en),
            trip ? 0 : 15);
    end

    // R1 reset clears a latched trip
    rst_n = 1'b0; wait_n(2); rst_n = 1'b1; @(negedge clk);
    check(trip == 1'b0 && gate_en == '1, "R1 reset clears trip", int'(trip), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule